// File: doc/BRIEF.md
# Two-Phase Low-Energy Tag CAM

This block is a small content-addressable tag store that sits beside a cache data array and answers "is this tag resident, and in which entry?". Entries are loaded through a write port carrying an entry index, a tag and a valid flag. A search takes a tag and returns a hit flag, a one-hot vector of every matching entry and the encoded index of the lowest matching entry, with a one-cycle done pulse.

Two search modes are selectable per search. In two-phase mode, each valid entry first compares only its 4 lowest tag bits. The upper tag bits are compared one cycle later, and only by entries that passed that first step. If no entry passes the first step, the search ends after one cycle with a miss. In parallel mode, all tag bits of all valid entries are compared at once and the result arrives one cycle after start. An output reports how many entries enabled their upper-bit comparator in the last search, so the gating can be observed.

Top module: `split_tag_cam`

## Requirements
- R1: After reset, done_o, hit_o, match_vec_o, match_idx_o and upper_cnt_o are all 0, and every entry is invalid.
- R2: A write applied while the block is idle stores tag and valid flag at wr_idx_i on that clock edge. An entry whose valid flag is 0 never matches and never enables an upper comparison.
- R3: In parallel mode (srch_serial_i = 0), a start accepted on one edge gives done_o = 1 for exactly one cycle after that edge. match_vec_o bit i is 1 exactly when entry i is valid and its full tag equals the search tag.
- R4: In two-phase mode (srch_serial_i = 1), upper_cnt_o reports the number of valid entries whose tag bits [3:0] equal the search tag bits [3:0]. Only those entries can appear in match_vec_o.
- R5: In two-phase mode with at least one low-bit match, done_o rises two cycles after the start edge. It is not asserted one cycle after that edge.
- R6: In two-phase mode with no low-bit match, done_o rises one cycle after the start edge, with hit_o = 0, match_vec_o = 0 and upper_cnt_o = 0.
- R7: In parallel mode, upper_cnt_o equals the number of valid entries.
- R8: hit_o is 1 exactly when match_vec_o is non-zero. match_idx_o is the lowest-numbered set bit of match_vec_o.
- R9: A write presented while a two-phase search is in its second cycle is discarded. The entry keeps its previous contents.
- R10: A start presented while a two-phase search is in its second cycle is ignored. A start in the cycle where done_o is high is accepted.
- R11: hit_o, match_vec_o, match_idx_o and upper_cnt_o hold their values until the next done_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write request |
| wr_idx_i | input | 4 | Entry written |
| wr_tag_i | input | 20 | Tag written |
| wr_valid_i | input | 1 | Valid flag written |
| srch_start_i | input | 1 | Start a search |
| srch_tag_i | input | 20 | Search tag, sampled at the start edge |
| srch_serial_i | input | 1 | 1 = two-phase, 0 = parallel |
| done_o | output | 1 | Result pulse |
| hit_o | output | 1 | Any entry matched |
| match_vec_o | output | 16 | All matching entries |
| match_idx_o | output | 4 | Lowest matching entry |
| upper_cnt_o | output | 5 | Upper comparators enabled in last search |

## Verification
The assertions assume that srch_tag_i and srch_serial_i are only meaningful at the edge where a start is accepted. They also assume that stored contents change only through accepted writes, so a tag captured for the second phase is compared against the same array the first phase saw. The stimulus drives every input on the falling edge. It pulses start for one cycle and waits for done before issuing the next search. The only exceptions are the directed cases that deliberately present a write or a second start during the second phase. Random tags are drawn from a small pool of low and upper fields, so that low-bit collisions, full matches and multiple matches all occur.

// File: rtl/split_cam_pkg.sv
package split_cam_pkg;
  localparam int unsigned LOW_W = 4;

  typedef enum logic {ST_IDLE = 1'b0, ST_PH2 = 1'b1} cam_state_e;

  function automatic int unsigned pop16(input logic [63:0] v, input int unsigned n);
    int unsigned c;
    c = 0;
    for (int unsigned i = 0; i < n; i++) c += v[i];
    return c;
  endfunction
endpackage

// File: rtl/cam_tag_array.sv
module cam_tag_array #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned TAG_W   = 20,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_ok_i,
  input  logic                            busy_i,
  input  logic [IDX_W-1:0]                wr_idx_i,
  input  logic [TAG_W-1:0]                wr_tag_i,
  input  logic                            wr_valid_i,
  output logic [ENTRIES-1:0][TAG_W-1:0]   tags_o,
  output logic [ENTRIES-1:0]              vld_o
);
  logic [ENTRIES-1:0][TAG_W-1:0] tags_q;
  logic [ENTRIES-1:0]            vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tags_q <= '0;
      vld_q  <= '0;
    end else if (wr_ok_i) begin
      tags_q[wr_idx_i] <= wr_tag_i;
      vld_q[wr_idx_i]  <= wr_valid_i;
    end
  end

  assign tags_o = tags_q;
  assign vld_o  = vld_q;

  // writes must not disturb contents while phase two reuses them
  assert_busy_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(tags_q) && $stable(vld_q)));
endmodule

// File: rtl/cam_compare.sv
module cam_compare #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned TAG_W   = 20
) (
  input  logic [ENTRIES-1:0][TAG_W-1:0] tags_i,
  input  logic [ENTRIES-1:0]            vld_i,
  input  logic [TAG_W-1:0]              key_i,
  input  logic [ENTRIES-1:0]            up_en_i,
  output logic [ENTRIES-1:0]            low_vec_o,
  output logic [ENTRIES-1:0]            up_vec_o
);
  import split_cam_pkg::*;
  localparam int unsigned UP_W = TAG_W - LOW_W;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_row
    logic low_eq, up_eq;
    assign low_eq = tags_i[g][LOW_W-1:0] == key_i[LOW_W-1:0];
    assign up_eq  = tags_i[g][TAG_W-1 -: UP_W] == key_i[TAG_W-1 -: UP_W];
    assign low_vec_o[g] = vld_i[g] & low_eq;
    assign up_vec_o[g]  = up_en_i[g] & up_eq;  // gated upper comparator
  end
endmodule

// File: rtl/cam_lowest_enc.sv
module cam_lowest_enc #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] vec_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/split_tag_cam.sv
module split_tag_cam #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned TAG_W   = 20,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [TAG_W-1:0]   wr_tag_i,
  input  logic               wr_valid_i,
  input  logic               srch_start_i,
  input  logic [TAG_W-1:0]   srch_tag_i,
  input  logic               srch_serial_i,
  output logic               done_o,
  output logic               hit_o,
  output logic [ENTRIES-1:0] match_vec_o,
  output logic [IDX_W-1:0]   match_idx_o,
  output logic [CNT_W-1:0]   upper_cnt_o
);
  import split_cam_pkg::*;

  cam_state_e                    st_q;
  logic [TAG_W-1:0]              key_q;
  logic [ENTRIES-1:0]            low_q;
  logic [ENTRIES-1:0]            vec_q;
  logic [CNT_W-1:0]              cnt_q;
  logic                          done_q;
  logic [ENTRIES-1:0][TAG_W-1:0] tags;
  logic [ENTRIES-1:0]            vld;
  logic [ENTRIES-1:0]            low_vec, up_vec, up_en, full_vec;
  logic [TAG_W-1:0]              key;
  logic                          idle, accept, wr_ok, busy;

  assign idle   = st_q == ST_IDLE;
  assign busy   = st_q == ST_PH2;
  assign accept = srch_start_i & idle;
  assign wr_ok  = wr_en_i & idle;
  assign key    = busy ? key_q : srch_tag_i;
  assign up_en  = busy ? low_q : (srch_serial_i ? '0 : vld);
  assign full_vec = low_vec & up_vec;

  cam_tag_array #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_ok_i(wr_ok), .busy_i(busy),
    .wr_idx_i(wr_idx_i), .wr_tag_i(wr_tag_i), .wr_valid_i(wr_valid_i),
    .tags_o(tags), .vld_o(vld)
  );

  cam_compare #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_cmp (
    .tags_i(tags), .vld_i(vld), .key_i(key), .up_en_i(up_en),
    .low_vec_o(low_vec), .up_vec_o(up_vec)
  );

  cam_lowest_enc #(.ENTRIES(ENTRIES)) u_enc (
    .vec_i(vec_q), .any_o(hit_o), .idx_o(match_idx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      key_q  <= '0;
      low_q  <= '0;
      vec_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy) begin
        vec_q  <= full_vec;
        cnt_q  <= CNT_W'(pop16(64'(low_q), ENTRIES));
        done_q <= 1'b1;
        st_q   <= ST_IDLE;
      end else if (accept) begin
        if (!srch_serial_i) begin
          vec_q  <= full_vec;
          cnt_q  <= CNT_W'(pop16(64'(vld), ENTRIES));
          done_q <= 1'b1;
        end else if (low_vec == '0) begin
          vec_q  <= '0;   // early out, phase two skipped
          cnt_q  <= '0;
          done_q <= 1'b1;
        end else begin
          key_q <= srch_tag_i;
          low_q <= low_vec;
          st_q  <= ST_PH2;
        end
      end
    end
  end

  assign done_o      = done_q;
  assign match_vec_o = vec_q;
  assign upper_cnt_o = cnt_q;

  assert_par_lat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !srch_serial_i) |=> done_o);
  assert_ph2_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> done_o);
  assert_ser_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && srch_serial_i && low_vec != '0) |=> !done_o);
  assert_early_out_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && srch_serial_i && low_vec == '0) |=> (done_o && !hit_o && upper_cnt_o == '0));
  assert_idx_lowest_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (match_vec_o[match_idx_o] && (match_vec_o & ((ENTRIES'(1) << match_idx_o) - ENTRIES'(1))) == '0));
  assert_gate_cnt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (upper_cnt_o >= CNT_W'($countones(match_vec_o))));
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> (done_o || ($stable(match_vec_o) && $stable(upper_cnt_o))));
endmodule

// File: tb/split_tag_cam_tb.sv
module split_tag_cam_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int TW = 20;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_valid = 0, start = 0, serial = 0;
  logic [3:0] wr_idx = 0;
  logic [TW-1:0] wr_tag = 0, s_tag = 0;
  logic done, hit;
  logic [N-1:0] mvec;
  logic [3:0] midx;
  logic [4:0] ucnt;

  logic [TW-1:0] m_tag [N];
  logic          m_vld [N];
  int n_chk = 0, n_bad = 0;
  bit timed_out = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_tag_cam dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_tag_i(wr_tag),
    .wr_valid_i(wr_valid), .srch_start_i(start), .srch_tag_i(s_tag), .srch_serial_i(serial),
    .done_o(done), .hit_o(hit), .match_vec_o(mvec), .match_idx_o(midx), .upper_cnt_o(ucnt)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_vec(input logic [TW-1:0] t);
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) v[i] = m_vld[i] && m_tag[i] == t;
    return v;
  endfunction

  function automatic int low_cnt(input logic [TW-1:0] t);
    int c = 0;
    for (int i = 0; i < N; i++) c += (m_vld[i] && m_tag[i][3:0] == t[3:0]) ? 1 : 0;
    return c;
  endfunction

  function automatic int vld_cnt();
    int c = 0;
    for (int i = 0; i < N; i++) c += m_vld[i] ? 1 : 0;
    return c;
  endfunction

  function automatic int low_idx(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic wr(input int idx, input logic [TW-1:0] t, input logic v);
    @(negedge clk);
    wr_en = 1; wr_idx = 4'(idx); wr_tag = t; wr_valid = v;
    @(negedge clk);
    wr_en = 0;
    m_tag[idx] = t; m_vld[idx] = v;
  endtask

  task automatic search(input logic [TW-1:0] t, input logic ser);
    logic [N-1:0] ev;
    int lc, lat, elat, ecnt;
    ev = exp_vec(t);
    lc = low_cnt(t);
    elat = (ser && lc > 0) ? 2 : 1;
    ecnt = ser ? lc : vld_cnt();
    @(negedge clk);
    start = 1; s_tag = t; serial = ser;
    @(negedge clk);
    start = 0;
    lat = 1;
    while (!done && lat < 6) begin
      @(negedge clk);
      lat++;
    end
    if (ser) chk(elat == 2 ? "R5 latency" : "R6 latency", lat, elat);
    else     chk("R3 latency", lat, elat);
    chk(ser ? "R4 match_vec" : "R3 match_vec", mvec, ev);
    chk(ser ? "R4 upper_cnt" : "R7 upper_cnt", ucnt, ecnt);
    chk("R8 hit", hit, ev != 0);
    if (ev != 0) chk("R8 idx", midx, low_idx(ev));
    @(negedge clk);
    chk("R3 done one cycle", done, 0);
    chk("R11 hold", mvec, ev);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    timed_out = 1;
  end

  initial begin : main
    logic [TW-1:0] t;
    logic [3:0] lows [4];
    logic [15:0] ups [3];
    void'($urandom(32'd7713));
    for (int i = 0; i < N; i++) begin m_tag[i] = 0; m_vld[i] = 0; end
    lows = '{4'h3, 4'h5, 4'hA, 4'hF};
    ups  = '{16'h0001, 16'hBEEF, 16'h7A00};
    repeat (3) @(negedge clk);
    chk("R1 done", done, 0); chk("R1 hit", hit, 0); chk("R1 vec", mvec, 0);
    chk("R1 idx", midx, 0); chk("R1 cnt", ucnt, 0);
    rst_n = 1;
    // R1/R6: empty array, serial early out
    search(20'h12345, 1);
    search(20'h00000, 0);
    // R2: invalid entry with matching tag does not match
    wr(2, 20'hBEEF3, 0);
    search(20'hBEEF3, 1);
    search(20'hBEEF3, 0);
    // R8: multiple matches, lowest index
    wr(9, 20'hBEEF3, 1); wr(5, 20'hBEEF3, 1); wr(12, 20'hBEEF3, 1);
    search(20'hBEEF3, 1);
    search(20'hBEEF3, 0);
    // R4/R5: low bits match, upper differ -> two cycles, miss
    wr(0, 20'h11113, 1);
    search(20'h77773, 1);
    // R6: low bits absent
    search(20'hBEEF6, 1);
    // R9: write during phase two discarded
    @(negedge clk);
    start = 1; s_tag = 20'hBEEF3; serial = 1;
    @(negedge clk);
    start = 0; wr_en = 1; wr_idx = 4'd5; wr_tag = 20'h00000; wr_valid = 0;
    @(negedge clk);
    wr_en = 0;
    chk("R9 done", done, 1);
    search(20'hBEEF3, 0);
    // R10: start in phase two ignored; start in done cycle accepted
    @(negedge clk);
    start = 1; s_tag = 20'hBEEF3; serial = 1;
    @(negedge clk);
    s_tag = 20'h11113; serial = 0;       // still high in phase two
    @(negedge clk);
    chk("R10 done after ph2", done, 1);
    chk("R10 vec from first", mvec, exp_vec(20'hBEEF3));
    start = 1; s_tag = 20'h11113; serial = 0; // accepted in done cycle
    @(negedge clk);
    start = 0;
    chk("R10 done-cycle start", done, 1);
    chk("R10 vec second", mvec, exp_vec(20'h11113));
    @(negedge clk);
    chk("R10 no extra done", done, 0);
    // random mix
    for (int k = 0; k < 60; k++) begin
      t = {ups[$urandom_range(0, 2)], lows[$urandom_range(0, 3)]};
      if ($urandom_range(0, 2) == 0)
        wr($urandom_range(0, N-1), t, 1'($urandom_range(0, 4) != 0));
      else
        search(t, 1'($urandom_range(0, 1)));
    end
    if (timed_out) begin n_chk++; n_bad++; $display("FAIL watchdog"); end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (timed_out);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule